// File: doc/BRIEF.md
# Port-Mapped Parallel I/O Card

This block models a small parallel I/O card on a 10-bit I/O address bus with an 8-bit data bus. It has four byte-wide output latches in one four-address window and four byte-wide input ports in a second four-address window. A write strobe with an address in the output window loads the addressed latch, and the latch drives eight output pins. A read strobe with an address in the input window returns the addressed input port and raises a valid flag.

Each input port works in one of two modes, set by one external level. While the level is high, a port is transparent and returns its pins as they are. While the level is low, a port returns the byte it captured at the last clock edge on which the level was still high. Accesses to the wrong window, or to any other address, have no effect.

Top module: `port_io_card`

## Requirements
- R1: While reset (`rstN` low) is applied, and on the first sample after it is released, `outPins` is all zeros, `rdValid` is 0 and `rdData` is 0x00.
- R2: An edge with `iowStrobe` high and `ioAddr` = 0x2B8 + k (k = 0..3) loads `wrData` into output latch k. From the next sample, the new value appears on `outPins[8k+7:8k]`, and the other three bytes are unchanged.
- R3: An output latch keeps its value on every edge that carries no write to its own address.
- R4: An edge with `iorStrobe` high and `ioAddr` = 0x2BC + k (k = 0..3) gives `rdValid` = 1 and `rdData` = the value of input port k from the next sample on.
- R5: When `inFollow` is 1 at the read edge, the value of input port k is `inPins[8k+7:8k]` as sampled on that edge.
- R6: When `inFollow` is 0 at the read edge, the value of input port k is `inPins[8k+7:8k]` as sampled on the last edge before it on which `inFollow` was 1. Pin changes while `inFollow` is 0 are not seen.
- R7: After any edge with no read of the input window, `rdValid` is 0 and `rdData` is 0x00. No port drives the data bus outside a read of its own address.
- R8: A read of 0x2B8..0x2BB or of any other address outside 0x2BC..0x2BF leaves `rdValid` at 0. A write to 0x2BC..0x2BF or to any other address outside 0x2B8..0x2BB leaves `outPins` unchanged.
- R9: A read and a write on the same edge are both carried out, each as if it were alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 10 | I/O address |
| iorStrobe | input | 1 | Read strobe, active high |
| iowStrobe | input | 1 | Write strobe, active high |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, 0x00 when no read is valid |
| rdValid | output | 1 | Read data valid |
| outPins | output | 32 | Output latch pins, latch k on bits 8k+7:8k |
| inPins | input | 32 | Input port pins, port k on bits 8k+7:8k |
| inFollow | input | 1 | 1 = input ports transparent, 0 = input ports hold |

## Verification
Two things can happen on the same edge: a read of an input port and a change of `inFollow`. When `inFollow` falls on the edge of a read, the read must return the byte held from the previous edge, not the pins present on the read edge. The bench provokes this by changing the pins in the same cycle as the fall. A write to a latch on the same edge as a read is provoked both in directed steps and in a random run with both strobes enabled. A behavioural model, updated on every edge, judges both outputs on every cycle.

// File: rtl/ioCardPkg.sv
package ioCardPkg;
  parameter int NPORTS = 4;

  typedef struct packed {
    logic [NPORTS-1:0] wrEn;
    logic [NPORTS-1:0] rdEn;
  } strobeT;
endpackage

// File: rtl/ioCardCtrl.sv
module ioCardCtrl
  import ioCardPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] WR_BASE = 10'h2B8,
  parameter logic [ADDR_W-1:0] RD_BASE = 10'h2BC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              iorStrobe,
  input  logic              iowStrobe,
  output strobeT            strobes
);
  for (genvar k = 0; k < NPORTS; k++) begin : g_dec
    localparam logic [ADDR_W-1:0] WR_ADDR = ADDR_W'(WR_BASE + k);
    localparam logic [ADDR_W-1:0] RD_ADDR = ADDR_W'(RD_BASE + k);
    assign strobes.wrEn[k] = iowStrobe && (ioAddr == WR_ADDR);
    assign strobes.rdEn[k] = iorStrobe && (ioAddr == RD_ADDR);
  end

  // R8: one address can never select a latch and a port together
  p_windows_disjoint_r8: assert property (@(posedge clk) disable iff (!rstN)
    !((|strobes.wrEn) && (|strobes.rdEn)));
  // R2: at most one latch is selected
  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrEn));
  // R4: at most one port is selected
  p_rd_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.rdEn));
endmodule

// File: rtl/ioCardDatapath.sv
module ioCardDatapath
  import ioCardPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PINS_W = NPORTS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              inFollow,
  input  logic [PINS_W-1:0] inPins,
  output logic [PINS_W-1:0] outPins,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] portVal [NPORTS];
  logic [DATA_W-1:0] heldQ   [NPORTS];
  logic [DATA_W-1:0] rdMux;

  for (genvar k = 0; k < NPORTS; k++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) outPins[k*DATA_W +: DATA_W] <= '0;
      else if (strobes.wrEn[k]) outPins[k*DATA_W +: DATA_W] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) heldQ[k] <= '0;
      else if (inFollow) heldQ[k] <= inPins[k*DATA_W +: DATA_W];
    end

    assign portVal[k] = inFollow ? inPins[k*DATA_W +: DATA_W] : heldQ[k];

    // R3: a latch without its own write keeps its byte
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrEn[k] |=> $stable(outPins[k*DATA_W +: DATA_W]));
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NPORTS; k++)
      if (strobes.rdEn[k]) rdMux = rdMux | portVal[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= rdMux;
      rdValid <= |strobes.rdEn;
    end
  end

  // R7: the bus stays quiet whenever no read is valid
  p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
  // R4: a selected port yields a valid read on the next cycle
  p_read_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.rdEn) |=> rdValid);
endmodule

// File: rtl/port_io_card.sv
module port_io_card
  import ioCardPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WR_BASE = 10'h2B8,
  parameter logic [ADDR_W-1:0] RD_BASE = 10'h2BC,
  localparam int PINS_W = NPORTS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              iorStrobe,
  input  logic              iowStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [PINS_W-1:0] outPins,
  input  logic [PINS_W-1:0] inPins,
  input  logic              inFollow
);
  strobeT strobes;

  ioCardCtrl #(.ADDR_W(ADDR_W), .WR_BASE(WR_BASE), .RD_BASE(RD_BASE)) ctrl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr),
    .iorStrobe(iorStrobe), .iowStrobe(iowStrobe), .strobes(strobes)
  );

  ioCardDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .inFollow(inFollow), .inPins(inPins), .outPins(outPins),
    .rdData(rdData), .rdValid(rdValid)
  );

  logic inRdWin;
  assign inRdWin = (int'(ioAddr) >= int'(RD_BASE)) && (int'(ioAddr) < int'(RD_BASE) + NPORTS);

  // R8: a read outside the input window never produces valid data
  p_stray_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(iorStrobe && inRdWin) |=> !rdValid);
endmodule

// File: tb/port_io_card_tb_top.sv
module port_io_card_tb_top;
  logic clk = 0, rstN = 0;
  logic [9:0] ioAddr = '0;
  logic iorStrobe = 0, iowStrobe = 0, inFollow = 1;
  logic [7:0] wrData = '0, rdData;
  logic rdValid;
  logic [31:0] outPins, inPins = '0;

  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  port_io_card dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .iorStrobe(iorStrobe),
    .iowStrobe(iowStrobe), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .outPins(outPins), .inPins(inPins), .inFollow(inFollow)
  );

  // behavioural reference
  logic [7:0] mOut [4];
  logic [7:0] mHeld [4];
  logic [7:0] mRd;
  logic mRdV;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < 4; k++) begin mOut[k] = 0; mHeld[k] = 0; end
      mRd = 0; mRdV = 0;
    end else begin
      mRd = 0; mRdV = 0;
      if (iorStrobe && ioAddr >= 10'h2BC && ioAddr <= 10'h2BF) begin
        mRdV = 1;
        mRd = inFollow ? inPins[(ioAddr - 10'h2BC) * 8 +: 8] : mHeld[ioAddr - 10'h2BC];
      end
      if (iowStrobe && ioAddr >= 10'h2B8 && ioAddr <= 10'h2BB)
        mOut[ioAddr - 10'h2B8] = wrData;
      if (inFollow)
        for (int k = 0; k < 4; k++) mHeld[k] = inPins[k*8 +: 8];
    end
  end

  task automatic compare(string tag);
    logic [31:0] expOut;
    expOut = {mOut[3], mOut[2], mOut[1], mOut[0]};
    nChk++;
    if (outPins !== expOut) begin
      nFail++;
      $display("FAIL %s outPins actual=%h expected=%h", tag, outPins, expOut);
    end
    nChk++;
    if (rdValid !== mRdV || rdData !== mRd) begin
      nFail++;
      $display("FAIL %s read actual=%b/%h expected=%b/%h", tag, rdValid, rdData, mRdV, mRd);
    end
  endtask

  task automatic step(bit rd, bit wr, logic [9:0] a, logic [7:0] d,
                      bit fol, logic [31:0] pins, string tag);
    iorStrobe = rd; iowStrobe = wr; ioAddr = a; wrData = d;
    inFollow = fol; inPins = pins;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expectRead(logic [7:0] e, string tag);
    nChk++;
    if (rdValid !== 1'b1 || rdData !== e) begin
      nFail++;
      $display("FAIL %s directed read actual=%b/%h expected=1/%h", tag, rdValid, rdData, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1;
    @(posedge clk); @(negedge clk);
    compare("R1");

    // writes to each latch
    step(0, 1, 10'h2B8, 8'hA1, 1, 32'h0, "R2");
    step(0, 1, 10'h2B9, 8'hB2, 1, 32'h0, "R2");
    step(0, 1, 10'h2BA, 8'hC3, 1, 32'h0, "R2");
    step(0, 1, 10'h2BB, 8'hD4, 1, 32'h0, "R2");
    nChk++;
    if (outPins !== 32'hD4C3B2A1) begin
      nFail++;
      $display("FAIL R2 latches actual=%h expected=d4c3b2a1", outPins);
    end
    step(0, 0, 10'h2B9, 8'hFF, 1, 32'h12345678, "R3");
    step(0, 0, 10'h2BA, 8'h00, 1, 32'h9ABCDEF0, "R3");
    // stray writes
    step(0, 1, 10'h2BC, 8'h55, 1, 32'h0, "R8");
    step(0, 1, 10'h2BF, 8'h55, 1, 32'h0, "R8");
    step(0, 1, 10'h2B7, 8'h55, 1, 32'h0, "R8");
    step(0, 1, 10'h0B8, 8'h55, 1, 32'h0, "R8");
    // transparent reads
    step(1, 0, 10'h2BC, 8'h0, 1, 32'h44332211, "R5");
    expectRead(8'h11, "R4");
    step(1, 0, 10'h2BF, 8'h0, 1, 32'h44332211, "R5");
    expectRead(8'h44, "R4");
    step(1, 0, 10'h2BD, 8'h0, 1, 32'h66778899, "R5");
    expectRead(8'h88, "R5");
    // last follow edge captures CAFEBABE; fall happens together with a read and pin change
    step(0, 0, 10'h0, 8'h0, 1, 32'hCAFEBABE, "R6");
    step(1, 0, 10'h2BE, 8'h0, 0, 32'h01020304, "R6");
    expectRead(8'hFE, "R6");
    step(1, 0, 10'h2BC, 8'h0, 0, 32'h0F0F0F0F, "R6");
    expectRead(8'hBE, "R6");
    step(1, 0, 10'h2BF, 8'h0, 0, 32'hFFFFFFFF, "R6");
    expectRead(8'hCA, "R6");
    // stray reads and idle
    step(1, 0, 10'h2B8, 8'h0, 1, 32'h11111111, "R8");
    step(1, 0, 10'h2BB, 8'h0, 1, 32'h11111111, "R8");
    step(1, 0, 10'h2C0, 8'h0, 1, 32'h11111111, "R8");
    step(0, 0, 10'h2BC, 8'h0, 1, 32'h11111111, "R7");
    // read and write together
    step(1, 1, 10'h2BD, 8'h77, 1, 32'h0000AB00, "R9");
    step(1, 1, 10'h2B9, 8'h66, 1, 32'h0, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [9:0] a;
      a = 10'h2B6 + 10'($urandom_range(0, 11));
      step(1'($urandom), 1'($urandom), a, 8'($urandom), ($urandom_range(0, 3) != 0),
           $urandom, "R9");
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule